// File: doc/BRIEF.md
# Low-Power Mode Controller

This block steps a processor system through six power modes and drives one clock-enable bit for each clock domain. The domains are the core, the time base and decrementer, the PLL, the memory controller, the real-time clock, the periodic interrupt timer and the communication module. A low communication bit puts that module in standby. Software asks for a mode with a one-cycle request strobe and a mode code. A request that selects the reduced-frequency mode also loads a clock gear value, and the gear output presents that value while the mode is active.

Mode requests are honoured only while the system runs at full power, which means full-high or full-low. Any other request is dropped and raises a sticky error flag. A wake input returns the system to full-high. From doze and sleep the return takes one cycle. From deep-sleep and low-power stop the controller first passes through a relock state. In that state only the PLL, real-time clock and periodic timer run, and the controller waits there for the PLL lock input before it enables the other domains. The PLL is modelled as its enable bit plus the lock input.

States: `S_FHIGH`, `S_FLOW`, `S_DOZE`, `S_SLEEP`, `S_DEEP`, `S_STOP`, `S_RELOCK`. Transitions: request accepted (from S_FHIGH or S_FLOW to the requested mode), fast wake (S_DOZE or S_SLEEP to S_FHIGH), slow wake (S_DEEP or S_STOP to S_RELOCK), lock seen (S_RELOCK to S_FHIGH).

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode is full-high (cur_mode = 0), all seven dom_en bits are 1, gear_sel = 0 and req_err = 0.
- R2: Mode codes are 0 full-high, 1 full-low, 2 doze, 3 sleep, 4 deep-sleep, 5 low-power stop and 6 relock. The dom_en bits are 0 core, 1 time base/decrementer, 2 PLL, 3 memory controller, 4 real-time clock, 5 periodic timer and 6 communication active. The enables per mode are: full-high and full-low 7'b1111111, doze 7'b0111110, sleep 7'b0110100, deep-sleep 7'b0110000, stop 7'b0000000, relock 7'b0110100.
- R3: An accepted request for code 1 loads req_gear. gear_sel shows that value while the mode is full-low and is 0 in every other mode.
- R4: In full-high or full-low, a req_valid with a code from 0 to 5 is accepted. On the next cycle cur_mode equals the code and dom_en follows R2.
- R5: A request is ignored and req_err is set on the next cycle in two cases: it arrives in doze, sleep, deep-sleep, stop or relock, or it carries code 6 or 7. In both cases the mode, dom_en and gear_sel stay unchanged.
- R6: req_err stays set until the next accepted request, which clears it on the cycle after.
- R7: wake in doze or sleep gives full-high with all enables on the next cycle.
- R8: wake in deep-sleep or stop enters relock on the next cycle. The controller stays in relock while pll_lock is 0. The cycle after pll_lock is seen at 1 in relock, the mode is full-high.
- R9: wake in full-high or full-low has no effect.
- R10: When wake and req_valid arrive in the same cycle in a low-power mode, the wake is taken and the request is ignored and flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_code | input | 3 | Requested mode code |
| req_gear | input | GEAR_W | Gear value loaded with a full-low request |
| wake | input | 1 | Wake-up event |
| pll_lock | input | 1 | PLL lock status |
| dom_en | output | 7 | Clock enables per domain (bit map in R2) |
| gear_sel | output | GEAR_W | Active clock gear divider setting |
| cur_mode | output | 3 | Present mode code |
| req_err | output | 1 | Sticky rejected-request flag |

## Verification
Two things can coincide in one cycle. A wake event can meet a mode request while the block sits in a low-power mode, and the PLL lock can meet a request in the relock state. The bench provokes the first by raising wake and req_valid on the same edge in doze and in deep-sleep. It then expects the wake path to win and req_err to rise. It provokes the second by sending a request during relock and expects it to be flagged while the relock timing stays as it was. Every source and requested code pair is swept, and the expected mode, enables, gear and error are computed in the bench.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int NDOM   = 7;
    localparam int MODE_W = 3;

    localparam int D_CORE = 0;
    localparam int D_TBD  = 1;
    localparam int D_PLL  = 2;
    localparam int D_MEMC = 3;
    localparam int D_RTC  = 4;
    localparam int D_PIT  = 5;
    localparam int D_COMM = 6;

    typedef enum logic [MODE_W-1:0] {
        S_FHIGH  = 3'd0,
        S_FLOW   = 3'd1,
        S_DOZE   = 3'd2,
        S_SLEEP  = 3'd3,
        S_DEEP   = 3'd4,
        S_STOP   = 3'd5,
        S_RELOCK = 3'd6
    } state_t;

    localparam logic [MODE_W-1:0] LAST_MODE = 3'd5;
endpackage

// File: rtl/lpm_req_check.sv
module lpm_req_check
    import lpm_pkg::*;
(
    input  state_t            state,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_code,
    output logic              accept,
    output logic              reject
);
    logic at_full;
    logic code_ok;

    always_comb begin
        at_full = (state == S_FHIGH) || (state == S_FLOW);
        code_ok = (req_code <= LAST_MODE);
        accept  = req_valid && at_full && code_ok;
        reject  = req_valid && !accept;
    end
endmodule

// File: rtl/lpm_domain_map.sv
module lpm_domain_map
    import lpm_pkg::*;
(
    input  state_t          state,
    output logic [NDOM-1:0] en
);
    always_comb begin
        en = '0;
        unique case (state)
            S_FHIGH, S_FLOW: en = '1;
            S_DOZE: begin
                en[D_TBD]  = 1'b1;
                en[D_PLL]  = 1'b1;
                en[D_MEMC] = 1'b1;
                en[D_RTC]  = 1'b1;
                en[D_PIT]  = 1'b1;
            end
            S_SLEEP, S_RELOCK: begin
                en[D_PLL] = 1'b1;
                en[D_RTC] = 1'b1;
                en[D_PIT] = 1'b1;
            end
            S_DEEP: begin
                en[D_RTC] = 1'b1;
                en[D_PIT] = 1'b1;
            end
            S_STOP: en = '0;
            default: en = '0;
        endcase
    end
endmodule

// File: rtl/lpm_gear.sv
module lpm_gear
    import lpm_pkg::*;
#(
    parameter int GEAR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  state_t            state,
    input  logic              accept,
    input  logic [MODE_W-1:0] req_code,
    input  logic [GEAR_W-1:0] req_gear,
    output logic [GEAR_W-1:0] gear_sel
);
    logic [GEAR_W-1:0] gear_q;

    always_ff @(posedge clk) begin
        if (rst)
            gear_q <= '0;
        else if (accept && req_code == S_FLOW)
            gear_q <= req_gear;
    end

    always_comb gear_sel = (state == S_FLOW) ? gear_q : '0;

    p_gear_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (state != S_FLOW) |-> (gear_sel == '0));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int GEAR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [MODE_W-1:0]       req_code,
    input  logic [GEAR_W-1:0]       req_gear,
    input  logic                    wake,
    input  logic                    pll_lock,
    output logic [NDOM-1:0]         dom_en,
    output logic [GEAR_W-1:0]       gear_sel,
    output logic [MODE_W-1:0]       cur_mode,
    output logic                    req_err
);
    state_t state_q, state_d;
    logic   accept, reject;

    lpm_req_check u_chk (
        .state     (state_q),
        .req_valid (req_valid),
        .req_code  (req_code),
        .accept    (accept),
        .reject    (reject)
    );

    lpm_domain_map u_map (
        .state (state_q),
        .en    (dom_en)
    );

    lpm_gear #(.GEAR_W(GEAR_W)) u_gear (
        .clk      (clk),
        .rst      (rst),
        .state    (state_q),
        .accept   (accept),
        .req_code (req_code),
        .req_gear (req_gear),
        .gear_sel (gear_sel)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FHIGH, S_FLOW: if (accept) state_d = state_t'(req_code);
            S_DOZE, S_SLEEP: if (wake) state_d = S_FHIGH;
            S_DEEP, S_STOP:  if (wake) state_d = S_RELOCK;
            S_RELOCK:        if (pll_lock) state_d = S_FHIGH;
            default:         state_d = S_FHIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FHIGH;
            req_err <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)
                req_err <= 1'b0;
            else if (reject)
                req_err <= 1'b1;
        end
    end

    always_comb cur_mode = state_q;

    p_low_req_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && state_q != S_FHIGH && state_q != S_FLOW) |=> req_err);
    p_low_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !wake && (state_q == S_DOZE || state_q == S_SLEEP))
        |=> (cur_mode == $past(cur_mode)));
    p_fast_wake_r7: assert property (@(posedge clk) disable iff (rst)
        (wake && (state_q == S_DOZE || state_q == S_SLEEP)) |=> (dom_en == '1));
    p_slow_wake_r8: assert property (@(posedge clk) disable iff (rst)
        (wake && (state_q == S_DEEP || state_q == S_STOP)) |=> (cur_mode == S_RELOCK));
    p_relock_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RELOCK) |-> (!dom_en[D_CORE] && dom_en[D_PLL] && !dom_en[D_MEMC]));
    p_relock_wait_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RELOCK && !pll_lock) |=> (cur_mode == S_RELOCK));
    p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_err);
endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [2:0]    req_code;
    logic [GW-1:0] req_gear;
    logic          wake;
    logic          pll_lock;
    logic [6:0]    dom_en;
    logic [GW-1:0] gear_sel;
    logic [2:0]    cur_mode;
    logic          req_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_ctrl #(.GEAR_W(GW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
        .req_gear(req_gear), .wake(wake), .pll_lock(pll_lock),
        .dom_en(dom_en), .gear_sel(gear_sel), .cur_mode(cur_mode), .req_err(req_err)
    );

    function automatic logic [6:0] exp_en(int m);
        case (m)
            0, 1: return 7'b1111111;
            2:    return 7'b0111110;
            3, 6: return 7'b0110100;
            4:    return 7'b0110000;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic chk(string rq, int m, int g, bit e);
        n_chk++;
        if (cur_mode !== 3'(m) || dom_en !== exp_en(m) || gear_sel !== GW'(g) || req_err !== e) begin
            n_bad++;
            $display("FAIL %s: mode=%0d en=%b gear=%0d err=%b expected mode=%0d en=%b gear=%0d err=%b",
                     rq, cur_mode, dom_en, gear_sel, req_err, m, exp_en(m), g, e);
        end
    endtask

    task automatic step(bit v, int code, int g, bit w);
        req_valid = v;
        req_code  = 3'(code);
        req_gear  = GW'(g);
        wake      = w;
        @(negedge clk);
        req_valid = 1'b0;
        wake      = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_code = '0; req_gear = '0; wake = 1'b0; pll_lock = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset", 0, 0, 1'b0);

        for (int src = 0; src < 2; src++) begin
            for (int code = 0; code < 8; code++) begin
                int g1 = (code % 7) + 1;
                int g2 = 7 - code;
                int gexp;
                bit lowm;
                if (src == 1) begin
                    step(1'b1, 1, g1, 1'b0);
                    chk("R3 enter full-low", 1, g1, 1'b0);
                end
                step(1'b1, code, g2, 1'b0);
                if (code > 5) begin
                    chk("R5 bad code ignored", src, src == 1 ? g1 : 0, 1'b1);
                    step(1'b1, 0, 0, 1'b0);
                    chk("R6 accept clears err", 0, 0, 1'b0);
                    continue;
                end
                gexp = (code == 1) ? g2 : 0;
                chk("R4 R2 accepted mode", code, gexp, 1'b0);
                if (code < 2) begin
                    step(1'b0, 0, 0, 1'b1);
                    chk("R9 wake in full mode", code, gexp, 1'b0);
                    step(1'b1, 0, 0, 1'b0);
                    chk("R4 back to full-high", 0, 0, 1'b0);
                    continue;
                end
                lowm = 1'b1;
                step(1'b1, 0, 5, 1'b0);
                chk("R5 request in low mode", code, 0, 1'b1);
                if (code == 2 || code == 4)
                    step(1'b1, 1, 6, 1'b1);
                else
                    step(1'b0, 0, 0, 1'b1);
                if (code < 4) begin
                    chk("R7 R10 fast wake", 0, 0, 1'b1);
                end else begin
                    chk("R8 R10 relock entered", 6, 0, 1'b1);
                    step(1'b1, 0, 0, 1'b0);
                    chk("R5 request in relock", 6, 0, 1'b1);
                    for (int k = 0; k < 3; k++) begin
                        step(1'b0, 0, 0, 1'b0);
                        chk("R8 wait for lock", 6, 0, 1'b1);
                    end
                    pll_lock = 1'b1;
                    step(1'b0, 0, 0, 1'b0);
                    pll_lock = 1'b0;
                    chk("R8 lock to full-high", 0, 0, 1'b1);
                end
                if (lowm) begin
                    step(1'b1, 0, 0, 1'b0);
                    chk("R6 err cleared", 0, 0, 1'b0);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule